// File: doc/BRIEF.md
# Edge-Sensing Pin Interrupt Controller

This block watches a bank of asynchronous input pins and raises a single interrupt request when a programmed edge shows up on any pin that is not masked. Each pin has its own two-bit edge selector, so it can respond to rising edges, falling edges, both, or nothing. Detection is edge-only; there is no level mode.

Software reaches every piece of state through one byte-wide register port. The edge selectors, the mask and the latched source flags each take several byte addresses. A source flag stays set until software writes a one to it. The request output `irq_n` is active low, so the host sees a new request as a falling edge.

The pins first pass through a two-stage synchronizer. An edge is found by comparing the newest synchronized sample with the sample taken one cycle earlier.

Top module: `gpio_edge_irq`

## Requirements
- R1: Each pin n has a two-bit edge selector at bits [2n+1:2n] of a 32-bit sense word. The encodings are: 2'b01 rising only, 2'b10 falling only, 2'b11 both edges, and 2'b00 no detection.
- R2: The sense word takes byte addresses 0 to 3, with the highest pins at the lowest address. Address 0 holds pins 15..12, address 1 holds pins 11..8, address 2 holds pins 7..4 and address 3 holds pins 3..0. Within each byte the highest pin sits in bits [7:6] and the lowest in bits [1:0]. Every byte reads back what was written to it.
- R3: The mask is at address 4 (pins 7..0, pin 0 in bit 0) and address 5 (pins 15..8). A mask bit of 1 stops an edge on that pin from setting its source flag.
- R4: The source flags are at address 6 (pins 7..0) and address 7 (pins 15..8). Writing a 1 to a bit clears that flag. Writing a 0 leaves the flag as it was.
- R5: Once set, a source flag stays set until it is cleared by a write. Masking the pin later does not clear it, and neither does the passing of time.
- R6: If a selected edge on an unmasked pin arrives in the same cycle as a write of 1 to that pin's flag, the flag ends up set.
- R7: `irq_n` is low exactly when at least one source flag is set. It is high when no flag is set.
- R8: After a synchronous reset, the sense word reads 0, both mask bytes read 8'hFF, both source bytes read 0, and `irq_n` is high.
- R9: Suppose a pin changes before clock edge k. Its source flag is still clear after edge k+1 and is set after edge k+2.
- R10: Addresses 8 and above read as 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | 16 | Asynchronous input pins |
| reg_addr | input | 8 | Byte address of the register port |
| reg_wr | input | 1 | Write strobe; the write takes effect at the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions take for granted that `reg_addr`, `reg_wr` and `reg_wdata` are stable around each rising clock edge, and that a write lasts exactly one cycle. They also assume reset is held for at least one clock edge before any check counts. The bench meets these conditions by changing every input on the falling clock edge and by holding reset for three cycles. Pin changes are likewise driven on falling edges, one transition at a time per case, so each detected edge can be traced to a single stimulus. The two-stage synchronizer then lines up each edge with a predictable cycle.

// File: rtl/gei_pkg.sv
// Package: shared definitions for the edge-sensing interrupt controller.
// Holds the edge-selector encoding and the per-pin match function.
package gei_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // Returns 1 when the selector accepts the edge seen on a pin.
    function automatic logic edge_match(input edge_sel_e sel, input logic rise, input logic fall);
        logic m;
        case (sel)
            EDGE_RISE: m = rise;
            EDGE_FALL: m = fall;
            EDGE_BOTH: m = rise | fall;
            default:   m = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gei_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherency required).
module gei_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-registers the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gei_edge_det.sv
// Module: per-pin edge detector with selector and mask.
// Assumes cur is already synchronous to clk. The output hit is
// combinational and valid for the cycle in which cur differs from
// the sample held from the previous cycle.
module gei_edge_det
    import gei_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   cur,
    input  logic [2*NPINS-1:0] sense,
    input  logic [NPINS-1:0]   mask,
    output logic [NPINS-1:0]   hit
);
    logic [NPINS-1:0] prev_q;

    // Hold last cycle's synchronized sample for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise, fall;
        assign rise   = cur[i] & ~prev_q[i];
        assign fall   = ~cur[i] & prev_q[i];
        assign hit[i] = ~mask[i] & edge_match(edge_sel_e'(sense[2*i +: 2]), rise, fall);
    end
endmodule

// File: rtl/gei_flags.sv
// Module: latched interrupt source flags with write-one-to-clear.
// Assumes clr and hit are valid during the same cycle. When both
// touch one bit, set wins.
module gei_flags #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] hit,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] flags
);
    // Clear requested bits first, then merge new hits on top.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | hit;
    end
endmodule

// File: rtl/gei_regs.sv
// Module: byte-addressed register file for sense and mask, clear decode
// for source flags, and read multiplexer.
// Assumes NPINS is a multiple of 8. Sense bytes start at address 0
// with the highest pins first; then come mask bytes, then source bytes.
module gei_regs #(
    parameter int NPINS = 16,
    parameter int AW    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      reg_addr,
    input  logic               reg_wr,
    input  logic [7:0]         reg_wdata,
    input  logic [NPINS-1:0]   src,
    output logic [7:0]         reg_rdata,
    output logic [2*NPINS-1:0] sense,
    output logic [NPINS-1:0]   mask,
    output logic [NPINS-1:0]   clr
);
    localparam int SENSE_BYTES = NPINS / 4;
    localparam int FLAG_BYTES  = NPINS / 8;
    localparam int MASK_BASE   = SENSE_BYTES;
    localparam int SRC_BASE    = MASK_BASE + FLAG_BYTES;

    // Store sense and mask bytes on writes to their addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense <= '0;
            mask  <= '1;
        end else if (reg_wr) begin
            for (int k = 0; k < SENSE_BYTES; k++) begin
                if (reg_addr == AW'(k))
                    sense[2*NPINS-1-8*k -: 8] <= reg_wdata;
            end
            for (int k = 0; k < FLAG_BYTES; k++) begin
                if (reg_addr == AW'(MASK_BASE + k))
                    mask[8*k +: 8] <= reg_wdata;
            end
        end
    end

    // Turn writes to source addresses into a per-pin clear vector.
    always_comb begin
        clr = '0;
        if (reg_wr) begin
            for (int k = 0; k < FLAG_BYTES; k++) begin
                if (reg_addr == AW'(SRC_BASE + k))
                    clr[8*k +: 8] = reg_wdata;
            end
        end
    end

    // Select the addressed byte; unmapped addresses return zero.
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < SENSE_BYTES; k++) begin
            if (reg_addr == AW'(k))
                reg_rdata = sense[2*NPINS-1-8*k -: 8];
        end
        for (int k = 0; k < FLAG_BYTES; k++) begin
            if (reg_addr == AW'(MASK_BASE + k))
                reg_rdata = mask[8*k +: 8];
            if (reg_addr == AW'(SRC_BASE + k))
                reg_rdata = src[8*k +: 8];
        end
    end
endmodule

// File: rtl/gpio_edge_irq.sv
// Module: edge-sensing pin interrupt controller (top).
// Synchronizes the pins, detects the selected edges on unmasked pins,
// latches them into write-one-to-clear flags and drives an active-low
// request. Assumes reset is held for at least one clock edge, and that
// software programs the sense word only after the pins have settled.
module gpio_edge_irq #(
    parameter int NPINS     = 16,
    parameter int AW        = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [AW-1:0]    reg_addr,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             irq_n
);
    logic [NPINS-1:0]   pin_sync;
    logic [2*NPINS-1:0] sense_q;
    logic [NPINS-1:0]   mask_q;
    logic [NPINS-1:0]   clr_vec;
    logic [NPINS-1:0]   hit_vec;
    logic [NPINS-1:0]   src_q;

    gei_sync #(.W(NPINS), .STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    gei_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .src(src_q), .reg_rdata(reg_rdata),
        .sense(sense_q), .mask(mask_q), .clr(clr_vec)
    );

    gei_edge_det #(.NPINS(NPINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .cur(pin_sync),
        .sense(sense_q), .mask(mask_q), .hit(hit_vec)
    );

    gei_flags #(.NPINS(NPINS)) u_flags (
        .clk(clk), .rst_n(rst_n), .hit(hit_vec), .clr(clr_vec), .flags(src_q)
    );

    // Request is low while any flag is pending.
    assign irq_n = ~|src_q;
endmodule

// File: rtl/gei_checker.sv
// Checker: temporal properties of the interrupt controller, bound to the top.
// Assumes register-port inputs are stable around each rising clock edge.
module gei_checker #(
    parameter int NPINS = 16,
    parameter int AW    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [AW-1:0]      reg_addr,
    input logic               reg_wr,
    input logic [7:0]         reg_wdata,
    input logic               irq_n,
    input logic [2*NPINS-1:0] sense_q,
    input logic [NPINS-1:0]   mask_q,
    input logic [NPINS-1:0]   src_q
);
    localparam int SRC_BASE = NPINS / 4 + NPINS / 8;
    localparam int END_ADDR = SRC_BASE + NPINS / 8;

    logic [NPINS-1:0] exp_clr;
    logic [NPINS-1:0] sel_on;
    logic             src_write;

    // Own decode of the write-one-to-clear vector from the port.
    always_comb begin
        exp_clr   = '0;
        src_write = 1'b0;
        for (int k = 0; k < NPINS / 8; k++) begin
            if (reg_wr && reg_addr == AW'(SRC_BASE + k)) begin
                exp_clr[8*k +: 8] = reg_wdata;
                src_write = 1'b1;
            end
        end
    end

    // Pins whose selector is not disabled.
    always_comb begin
        for (int i = 0; i < NPINS; i++) sel_on[i] = |sense_q[2*i +: 2];
    end

    a_r8_reset_state: assert property (@(posedge clk)
        !rst_n |=> (sense_q == '0 && mask_q == '1 && src_q == '0));

    a_r3_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((src_q & ~$past(src_q) & $past(mask_q)) == '0));

    a_r1_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((src_q & ~$past(src_q) & ~$past(sel_on)) == '0));

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(src_q) & ~$past(exp_clr)) & ~src_q) == '0));

    a_r7_release_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> $past(src_write));

    a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr >= AW'(END_ADDR)) |=> ($stable(sense_q) && $stable(mask_q)));
endmodule

bind gpio_edge_irq gei_checker #(.NPINS(NPINS), .AW(AW)) u_gei_checker (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .irq_n(irq_n), .sense_q(sense_q),
    .mask_q(mask_q), .src_q(src_q)
);

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] pins;
    logic [7:0]  reg_addr;
    logic        reg_wr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_edge_irq i_gpio_edge_irq (
        .clk(clk), .rst_n(rst_n), .pin_in(pins), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_src(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(8'd6, lo);
        rd(8'd7, hi);
        v = {hi, lo};
    endtask

    task automatic clear_all();
        wr(8'd6, 8'hFF);
        wr(8'd7, 8'hFF);
    endtask

    task automatic drive(input logic [15:0] p);
        @(negedge clk);
        pins = p;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] s;
        rst_n = 1'b0; pins = '0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset values
        for (int a = 0; a < 4; a++) begin
            rd(8'(a), b);
            chk("R8 sense reset", {8'h0, b}, 16'h0);
        end
        rd(8'd4, b); chk("R8 mask lo reset", {8'h0, b}, 16'h00FF);
        rd(8'd5, b); chk("R8 mask hi reset", {8'h0, b}, 16'h00FF);
        rd_src(s);   chk("R8 src reset", s, 16'h0);
        chk("R8 irq_n reset", {15'h0, irq_n}, 16'h1);

        // R3: all masked after reset, with all edges selected nothing sets
        for (int a = 0; a < 4; a++) wr(8'(a), 8'hFF);
        drive(16'hFFFF);
        rd_src(s); chk("R3 masked after reset", s, 16'h0);
        drive(16'h0000);

        // R2: sense readback per byte
        for (int a = 0; a < 4; a++) wr(8'(a), 8'(8'h11 * (a + 3)));
        for (int a = 0; a < 4; a++) begin
            rd(8'(a), b);
            chk("R2 sense readback", {8'h0, b}, {8'h0, 8'(8'h11 * (a + 3))});
        end

        // R3: only pin 3 unmasked
        for (int a = 0; a < 4; a++) wr(8'(a), 8'hFF);
        wr(8'd4, 8'hF7); wr(8'd5, 8'hFF);
        drive(16'hFFFF);
        rd_src(s); chk("R3 only unmasked pin sets", s, 16'h0008);
        chk("R7 irq_n low when flag set", {15'h0, irq_n}, 16'h0);
        clear_all();
        rd_src(s); chk("R4 clear by ones", s, 16'h0);
        chk("R7 irq_n high when clear", {15'h0, irq_n}, 16'h1);
        drive(16'h0000);
        rd_src(s); chk("R3 falling on unmasked pin", s, 16'h0008);
        clear_all();

        // R1, R2: exhaustive sweep of pins, selector codes and directions
        wr(8'd4, 8'h00); wr(8'd5, 8'h00);
        for (int p = 0; p < 16; p++) begin
            for (int c = 0; c < 4; c++) begin
                logic [15:0] er, ef;
                for (int a = 0; a < 4; a++)
                    wr(8'(a), (a == 3 - p / 4) ? 8'(c << (2 * (p % 4))) : 8'h00);
                er = c[0] ? 16'(1 << p) : 16'h0;
                ef = c[1] ? 16'(1 << p) : 16'h0;
                drive(16'(1 << p));
                rd_src(s); chk("R1 rising sweep", s, er);
                chk("R7 irq_n rising sweep", {15'h0, irq_n}, {15'h0, er == 16'h0});
                clear_all();
                drive(16'h0000);
                rd_src(s); chk("R1 falling sweep", s, ef);
                chk("R7 irq_n falling sweep", {15'h0, irq_n}, {15'h0, ef == 16'h0});
                clear_all();
            end
        end

        // R9: latency of two synchronizer stages plus the flag register
        for (int a = 0; a < 4; a++) wr(8'(a), (a == 3) ? 8'h01 : 8'h00);
        @(negedge clk); pins = 16'h0001;
        @(negedge clk);
        @(negedge clk);
        rd_src(s); chk("R9 not yet set after k+1", s, 16'h0);
        @(negedge clk);
        rd_src(s); chk("R9 set after k+2", s, 16'h0001);
        clear_all();
        drive(16'h0000);

        // R4: writing zeros leaves flags; R5 sticky under later masking
        for (int a = 0; a < 4; a++) wr(8'(a), (a == 2) ? 8'h0C : 8'h00);
        drive(16'h0020);
        wr(8'd6, 8'h00); wr(8'd7, 8'hFF);
        rd_src(s); chk("R4 zero write leaves flag", s, 16'h0020);
        wr(8'd4, 8'hFF);
        repeat (10) @(negedge clk);
        rd_src(s); chk("R5 flag sticky after mask", s, 16'h0020);
        chk("R5 irq_n held", {15'h0, irq_n}, 16'h0);
        wr(8'd4, 8'h00);

        // R6: new edge lands in the same cycle as a clear of that bit
        @(negedge clk); pins = 16'h0000;
        @(negedge clk);
        @(negedge clk);
        reg_addr = 8'd6; reg_wdata = 8'h20; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        rd_src(s); chk("R6 set wins over clear", s, 16'h0020);
        wr(8'd6, 8'h20);
        rd_src(s); chk("R4 plain clear", s, 16'h0);

        // R10: unmapped addresses
        wr(8'd8, 8'h55);
        wr(8'hF0, 8'hAA);
        rd(8'd8, b);  chk("R10 unmapped reads zero", {8'h0, b}, 16'h0);
        rd(8'hF0, b); chk("R10 high address reads zero", {8'h0, b}, 16'h0);
        rd(8'd2, b);  chk("R10 sense unchanged", {8'h0, b}, 16'h000C);
        rd(8'd4, b);  chk("R10 mask unchanged", {8'h0, b}, 16'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule